// File: doc/BRIEF.md
# ARINC 429 Word Receiver with Label-Bit Filter

This block turns an already-digitized, three-level serial line into 32-bit words. The line state arrives on a pair of wires: positive-only means a one, negative-only means a zero, neither means null, and both at once is an illegal state. Each bit cell has two halves. In the first half the line is driven to one or zero. In the second half it returns to null. Bit 1 of a word arrives first. After bit 32, the line must stay null for a minimum gap before the word counts as complete.

A complete word can be filtered on its bits 9 and 10 against two programmed compare bits. An accepted word goes into a holding register, and its parity (odd parity over all 32 bits) is flagged. The host reads the word as two 16-bit halves through a shared bus, with a select line choosing the half. A loopback control swaps the line input for the local transmitter's serial output, so the receiver can check its own transmitter. The half-bit sampling rate comes from the block clock divided by 10 or by 80.

The control state machine has five states:
- `ST_GAP`: waits for a run of null half-bits, then moves to `ST_IDLE`. Any non-null half-bit restarts the count.
- `ST_IDLE`: a data half-bit captures bit 1 and moves to `ST_HALF_NULL`. An illegal half-bit moves to `ST_GAP`.
- `ST_HALF_NULL`: a null half-bit moves to `ST_BIT`, or to `ST_TAIL` after the 32nd bit. Anything else moves to `ST_GAP`.
- `ST_BIT`: a data half-bit captures the next bit and moves to `ST_HALF_NULL`. Anything else moves to `ST_GAP`.
- `ST_TAIL`: a full gap of null half-bits commits the word and moves to `ST_IDLE`. Any non-null half-bit drops the word and moves to `ST_GAP`.

Top module: `a429_word_rx`

## Requirements
- R1: The half-bit sampling period is 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1. A word timed for 80-clock halves is not accepted when `rate_slow`=0.
- R2: Line pair encoding {pos,neg}: 10 = one, 01 = zero, 00 = null, 11 = illegal. A word that contains an illegal half-bit is discarded.
- R3: Bit 1 is received first. A word must have exactly 32 bits, each an active half followed by a null half. A word with fewer bits is discarded.
- R4: A word is stored only after at least 4 bit-times (8 half-bits) of null follow bit 32. An active half-bit in that window (a 33rd bit) discards the word.
- R5: On store, `parity_err` is set to 1 when the count of ones over the 32 bits is even, and to 0 when it is odd. The word is stored in both cases.
- R6: When `filt_en`=1, a word is stored only if its bit 9 equals `filt_b9` and its bit 10 equals `filt_b10`. When `filt_en`=0, the filter does not apply.
- R7: When `loop_n`=0, the receiver takes `tx_pos`/`tx_neg` and ignores `line_pos`/`line_neg`. When `loop_n`=1, it takes the line pins.
- R8: With `rd_half`=0, `rd_data` carries:
  - bits 15..11 = word bits 13..9
  - bit 10 = word bit 31
  - bit 9 = word bit 30
  - bit 8 = word bit 32
  - bits 7..0 = word bits 1..8, with bit 7 = word bit 1
- R9: With `rd_half`=1, `rd_data` bits 15..0 carry word bits 29..14.
- R10: `word_ready` rises when a word is stored. It falls on the clock after both halves have been read with `rd_en`. Reading one half, even repeatedly, leaves it set.
- R11: During reset, `word_ready` and `parity_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pos | input | 1 | Line positive-level detect |
| line_neg | input | 1 | Line negative-level detect |
| tx_pos | input | 1 | Local transmitter positive output (loopback source) |
| tx_neg | input | 1 | Local transmitter negative output (loopback source) |
| loop_n | input | 1 | 0 = take the transmitter outputs, 1 = take the line |
| rate_slow | input | 1 | 0 = clock/10 half-bit rate, 1 = clock/80 |
| filt_en | input | 1 | Enable the bit 9/10 filter |
| filt_b9 | input | 1 | Compare value for word bit 9 |
| filt_b10 | input | 1 | Compare value for word bit 10 |
| rd_en | input | 1 | Read strobe for the selected half |
| rd_half | input | 1 | 0 = first bus half, 1 = second bus half |
| rd_data | output | 16 | Selected half of the held word |
| word_ready | output | 1 | A stored word is waiting to be read |
| parity_err | output | 1 | The held word has even parity |

## Verification
A wrong bit counter or a wrong shift index in the state machine shows up as scrambled fields in `rd_data` once the next word is stored. This is about two clocks after the last gap half-bit. A state machine that stays in a failure state, or leaves it too early, shows up as a missing or extra `word_ready` rise at that same point. The stimulus therefore includes short words, long words and words with illegal half-bits, each followed by a clean word. A read-flag fault shows up on the clock after a read strobe, as `word_ready` falling after one half or staying set after both.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    localparam int WORD_BITS = 32;

    typedef enum logic [1:0] {
        SYM_NULL = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_ZERO = 2'b10,
        SYM_BAD  = 2'b11
    } sym_t;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_IDLE,
        ST_HALF_NULL,
        ST_BIT,
        ST_TAIL
    } rx_state_t;

    function automatic sym_t decode_pair(input logic pos, input logic neg);
        sym_t s;
        unique case ({pos, neg})
            2'b10:   s = SYM_ONE;
            2'b01:   s = SYM_ZERO;
            2'b00:   s = SYM_NULL;
            default: s = SYM_BAD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/a429_rate_div.sv
module a429_rate_div #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    output logic tick
);
    localparam int CW = $clog2(DIV_SLOW + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/a429_sym_front.sv
module a429_sym_front
    import a429_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_n,
    input  logic line_pos,
    input  logic line_neg,
    input  logic tx_pos,
    input  logic tx_neg,
    output sym_t sym
);
    sym_t pipe [SYNC_STAGES];
    logic raw_pos;
    logic raw_neg;

    assign raw_pos = loop_n ? line_pos : tx_pos;
    assign raw_neg = loop_n ? line_neg : tx_neg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= SYM_NULL;
        end else begin
            pipe[0] <= decode_pair(raw_pos, raw_neg);
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign sym = pipe[SYNC_STAGES-1];
endmodule

// File: rtl/a429_rx_fsm.sv
module a429_rx_fsm
    import a429_rx_pkg::*;
#(
    parameter int GAP_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  sym_t                 sym,
    output logic                 frame_done,
    output logic [WORD_BITS-1:0] frame
);
    localparam int GAP_HALVES = 2 * GAP_BITS;
    localparam int GW = $clog2(GAP_HALVES + 1);
    localparam int BW = $clog2(WORD_BITS + 1);
    localparam int IW = $clog2(WORD_BITS);

    rx_state_t state;
    rx_state_t nxt;

    logic [GW-1:0]        gapcnt;
    logic [BW-1:0]        bitcnt;
    logic [WORD_BITS-1:0] shreg;
    logic                 is_data;
    logic                 is_null;
    logic                 gap_full;
    logic                 last_bit;

    assign is_data  = (sym == SYM_ONE) || (sym == SYM_ZERO);
    assign is_null  = (sym == SYM_NULL);
    assign gap_full = (gapcnt == GW'(GAP_HALVES - 1));
    assign last_bit = (bitcnt == BW'(WORD_BITS));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_GAP;
        else        state <= nxt;
    end

    // transitions, evaluated once per half-bit tick
    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                ST_GAP: begin
                    if (is_null && gap_full) nxt = ST_IDLE;
                end
                ST_IDLE: begin
                    if (is_data)             nxt = ST_HALF_NULL;
                    else if (sym == SYM_BAD) nxt = ST_GAP;
                end
                ST_HALF_NULL: begin
                    if (is_null) nxt = last_bit ? ST_TAIL : ST_BIT;
                    else         nxt = ST_GAP;
                end
                ST_BIT: begin
                    nxt = is_data ? ST_HALF_NULL : ST_GAP;
                end
                ST_TAIL: begin
                    if (!is_null)      nxt = ST_GAP;
                    else if (gap_full) nxt = ST_IDLE;
                end
                default: nxt = ST_GAP;
            endcase
        end
    end

    // outputs and word assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gapcnt     <= '0;
            bitcnt     <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_GAP: begin
                        if (!is_null || gap_full) gapcnt <= '0;
                        else                      gapcnt <= gapcnt + 1'b1;
                    end
                    ST_IDLE: begin
                        gapcnt <= '0;
                        if (is_data) begin
                            shreg[0] <= (sym == SYM_ONE);
                            bitcnt   <= BW'(1);
                        end
                    end
                    ST_HALF_NULL: begin
                        gapcnt <= '0;
                    end
                    ST_BIT: begin
                        gapcnt <= '0;
                        if (is_data) begin
                            shreg[bitcnt[IW-1:0]] <= (sym == SYM_ONE);
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        if (!is_null) begin
                            gapcnt <= '0;
                        end else if (gap_full) begin
                            gapcnt     <= '0;
                            frame_done <= 1'b1;
                        end else begin
                            gapcnt <= gapcnt + 1'b1;
                        end
                    end
                    default: gapcnt <= '0;
                endcase
            end
        end
    end

    assign frame = shreg;
endmodule

// File: rtl/a429_word_hold.sv
module a429_word_hold
    import a429_rx_pkg::*;
#(
    parameter int SEL_LO_IDX = 8,
    parameter int SEL_HI_IDX = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [WORD_BITS-1:0] frame,
    input  logic                 filt_en,
    input  logic                 filt_b9,
    input  logic                 filt_b10,
    input  logic                 rd_en,
    input  logic                 rd_half,
    output logic [WORD_BITS-1:0] held,
    output logic                 word_ready,
    output logic                 parity_err
);
    logic accept;
    logic got_lo;
    logic got_hi;
    logic lo_nxt;
    logic hi_nxt;

    assign accept = !filt_en ||
                    ((frame[SEL_LO_IDX] == filt_b9) && (frame[SEL_HI_IDX] == filt_b10));
    assign lo_nxt = got_lo | ~rd_half;
    assign hi_nxt = got_hi | rd_half;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held       <= '0;
            word_ready <= 1'b0;
            parity_err <= 1'b0;
            got_lo     <= 1'b0;
            got_hi     <= 1'b0;
        end else if (frame_done && accept) begin
            held       <= frame;
            word_ready <= 1'b1;
            parity_err <= ~^frame;
            got_lo     <= 1'b0;
            got_hi     <= 1'b0;
        end else if (rd_en && word_ready) begin
            if (lo_nxt && hi_nxt) begin
                word_ready <= 1'b0;
                got_lo     <= 1'b0;
                got_hi     <= 1'b0;
            end else begin
                got_lo <= lo_nxt;
                got_hi <= hi_nxt;
            end
        end
    end
endmodule

// File: rtl/a429_bus_pack.sv
module a429_bus_pack
    import a429_rx_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic [WORD_BITS-1:0] held,
    input  logic                 rd_half,
    output logic [BUS_W-1:0]     rd_data
);
    localparam int LSB_W = 8;

    logic [BUS_W-1:0] lo_half;
    logic [BUS_W-1:0] hi_half;

    assign lo_half[15:11] = held[12:8];
    assign lo_half[10]    = held[30];
    assign lo_half[9]     = held[29];
    assign lo_half[8]     = held[31];

    for (genvar g = 0; g < LSB_W; g++) begin : g_rev
        assign lo_half[LSB_W-1-g] = held[g];
    end

    assign hi_half = held[28:13];
    assign rd_data = rd_half ? hi_half : lo_half;
endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
    import a429_rx_pkg::*;
#(
    parameter int DIV_FAST    = 10,
    parameter int DIV_SLOW    = 80,
    parameter int GAP_BITS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_pos,
    input  logic        line_neg,
    input  logic        tx_pos,
    input  logic        tx_neg,
    input  logic        loop_n,
    input  logic        rate_slow,
    input  logic        filt_en,
    input  logic        filt_b9,
    input  logic        filt_b10,
    input  logic        rd_en,
    input  logic        rd_half,
    output logic [15:0] rd_data,
    output logic        word_ready,
    output logic        parity_err
);
    logic                 tick;
    sym_t                 sym;
    logic                 frame_done;
    logic [WORD_BITS-1:0] frame;
    logic [WORD_BITS-1:0] held;

    a429_rate_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk(clk), .rst_n(rst_n), .slow(rate_slow), .tick(tick)
    );

    a429_sym_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .loop_n(loop_n),
        .line_pos(line_pos), .line_neg(line_neg),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .sym(sym)
    );

    a429_rx_fsm #(.GAP_BITS(GAP_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sym(sym),
        .frame_done(frame_done), .frame(frame)
    );

    a429_word_hold u_hold (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame(frame),
        .filt_en(filt_en), .filt_b9(filt_b9), .filt_b10(filt_b10),
        .rd_en(rd_en), .rd_half(rd_half), .held(held),
        .word_ready(word_ready), .parity_err(parity_err)
    );

    a429_bus_pack u_pack (
        .held(held), .rd_half(rd_half), .rd_data(rd_data)
    );
endmodule

// File: rtl/a429_word_rx_chk.sv
module a429_word_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        frame_done,
    input logic [31:0] frame,
    input logic        filt_en,
    input logic        filt_b9,
    input logic        filt_b10,
    input logic        rd_en,
    input logic        word_ready,
    input logic        parity_err
);
    // R1: a finished word is only reported on a sampling tick
    a_r1_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(tick));

    // R10: ready only falls after a read strobe
    a_r10_fall_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_ready) |-> $past(rd_en));

    // R6: a mismatching word never raises ready
    a_r6_filter_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && filt_en && ((frame[8] != filt_b9) || (frame[9] != filt_b10)))
        |=> !$rose(word_ready));

    // R5: an unfiltered word is stored with its parity flag
    a_r5_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !filt_en) |=> (word_ready && (parity_err == ~^$past(frame))));

    // R11: reset clears the flags
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!word_ready && !parity_err));
endmodule

bind a429_word_rx a429_word_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_done(frame_done),
    .frame(frame), .filt_en(filt_en), .filt_b9(filt_b9), .filt_b10(filt_b10),
    .rd_en(rd_en), .word_ready(word_ready), .parity_err(parity_err)
);

// File: tb/sim_a429_word_rx.sv
`timescale 1ns/1ps
module sim_a429_word_rx;
    logic        clk = 1'b0;
    logic        rst_n, line_pos, line_neg, tx_pos, tx_neg, loop_n, rate_slow;
    logic        filt_en, filt_b9, filt_b10, rd_en, rd_half;
    logic [15:0] rd_data;
    logic        word_ready, parity_err;

    int n_chk = 0;
    int n_err = 0;
    int half_clks = 10;
    bit use_tx = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    a429_word_rx u0 (.*);

    typedef struct packed {
        logic [31:0] w;
        logic fe; logic b9; logic b10; logic acc;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'hC000_0003, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b1},
        '{32'h1234_5678, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1},
        '{32'hA5A5_0F0F, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0000_0300, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    function automatic logic [15:0] exp_lo(input logic [31:0] w);
        logic [15:0] r;
        r[15:11] = {w[12], w[11], w[10], w[9], w[8]};
        r[10] = w[30];
        r[9]  = w[29];
        r[8]  = w[31];
        for (int k = 0; k < 8; k++) r[7-k] = w[k];
        return r;
    endfunction

    function automatic logic [15:0] exp_hi(input logic [31:0] w);
        return w[28:13];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic p, input logic n, input int halves);
        repeat (halves * half_clks) begin
            @(negedge clk);
            if (use_tx) begin tx_pos = p; tx_neg = n; end
            else        begin line_pos = p; line_neg = n; end
        end
    endtask

    task automatic send_word(input logic [31:0] w, input int nbits, input int bad_at);
        put(1'b0, 1'b0, 10);
        for (int i = 0; i < nbits; i++) begin
            if (i == bad_at) put(1'b1, 1'b1, 1);
            else             put(w[i % 32], ~w[i % 32], 1);
            put(1'b0, 1'b0, 1);
        end
        put(1'b0, 1'b0, 12);
    endtask

    task automatic rd(input logic h, output logic [15:0] d);
        @(negedge clk);
        rd_half = h;
        rd_en   = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // read both halves and check packing and ready handling
    task automatic read_word(input logic [31:0] w);
        logic [15:0] d;
        rd(1'b0, d);
        chk("R8 first half", 32'(d), 32'(exp_lo(w)));
        chk("R10 ready held after one half", 32'(word_ready), 32'd1);
        rd(1'b1, d);
        chk("R9 second half", 32'(d), 32'(exp_hi(w)));
        chk("R10 ready cleared after both", 32'(word_ready), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        rst_n = 0; line_pos = 0; line_neg = 0; tx_pos = 0; tx_neg = 0;
        loop_n = 1; rate_slow = 0; filt_en = 0; filt_b9 = 0; filt_b10 = 0;
        rd_en = 0; rd_half = 0;
        repeat (5) @(negedge clk);
        chk("R11 ready in reset", 32'(word_ready), 32'd0);
        chk("R11 parity flag in reset", 32'(parity_err), 32'd0);
        rst_n = 1;

        // table of words: filter, parity, packing
        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            filt_en = VECS[v].fe; filt_b9 = VECS[v].b9; filt_b10 = VECS[v].b10;
            send_word(VECS[v].w, 32, -1);
            chk("R6 accept decision", 32'(word_ready), 32'(VECS[v].acc));
            if (VECS[v].acc) begin
                chk("R5 parity flag", 32'(parity_err), 32'(~^VECS[v].w));
                read_word(VECS[v].w);
            end
        end
        filt_en = 0;

        // R10: repeated reads of one half keep ready set
        send_word(32'h0000_00FF, 32, -1);
        chk("R5 even parity stored", 32'(parity_err), 32'd1);
        rd(1'b1, d);
        chk("R10 ready after second half only", 32'(word_ready), 32'd1);
        rd(1'b1, d);
        chk("R10 ready after repeat read", 32'(word_ready), 32'd1);
        rd(1'b0, d);
        chk("R10 ready cleared", 32'(word_ready), 32'd0);

        // R2: illegal half-bit discards the word
        send_word(32'h1357_9BDF, 32, 5);
        chk("R2 illegal symbol discards", 32'(word_ready), 32'd0);
        // R3: short word discarded
        send_word(32'h1357_9BDF, 31, -1);
        chk("R3 short word discarded", 32'(word_ready), 32'd0);
        // R4: 33rd bit inside gap discards
        send_word(32'h1357_9BDF, 33, -1);
        chk("R4 long word discarded", 32'(word_ready), 32'd0);
        // recovery with a clean word, bit 1 first
        send_word(32'h8000_0002, 32, -1);
        chk("R3 clean word after errors", 32'(word_ready), 32'd1);
        read_word(32'h8000_0002);

        // R1: slow rate
        @(negedge clk);
        rate_slow = 1; half_clks = 80;
        send_word(32'h5555_AAAA, 32, -1);
        chk("R1 slow-rate word accepted", 32'(word_ready), 32'd1);
        read_word(32'h5555_AAAA);
        rate_slow = 0;
        send_word(32'h5555_AAAA, 32, -1);
        chk("R1 slow timing rejected at fast rate", 32'(word_ready), 32'd0);
        half_clks = 10;

        // R7: loopback takes the transmitter pins, line ignored
        @(negedge clk);
        loop_n = 0; line_pos = 1; line_neg = 1; use_tx = 1;
        send_word(32'h0F0F_1234, 32, -1);
        chk("R7 loopback word accepted", 32'(word_ready), 32'd1);
        read_word(32'h0F0F_1234);
        tx_pos = 0; tx_neg = 0; use_tx = 0;
        send_word(32'h0F0F_1234, 32, -1);
        chk("R7 line ignored in loopback", 32'(word_ready), 32'd0);
        loop_n = 1;
        send_word(32'h0000_0007, 32, -1);
        chk("R7 line used again", 32'(word_ready), 32'd1);
        read_word(32'h0000_0007);

        done = 1;
        finish_run();
    end
endmodule